// File: doc/BRIEF.md
# Vectored Interrupt Pending Controller

This block gathers interrupt requests from a set of peripheral sources and turns them into one vector request at a time for the processor core. Each source owns a flag bit and an enable bit. The bits are packed eight to a byte in two register banks: flags and enables. The block keeps its own pending set next to the flags. That set changes when a peripheral raises a flag, when software writes an enable byte, when software clears flags by writing ones, and when the core accepts a vector.

Among the pending sources, the lowest-numbered one is offered to the core through a valid/ready handshake, together with its vector address. The offer is made only while the global interrupt enable input is high. Sources are either pulse-type or level-type, chosen per source by a parameter:

- A pulse-type source is retired when the core accepts it.
- A level-type source stays pending until software masks it or clears it.

After each acceptance the block waits out the core's two-cycle interrupt entry before it offers the next vector.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A pulse on `setStb[i]` for a pulse-type source sets flag i. If enable i is 1 after that cycle's writes, source i also becomes pending.
- R2: A set on a source whose enable is 0 sets its flag but produces no dispatch. Writing its enable bit to 1 later, while the flag is still 1, makes it pending on the next cycle.
- R3: Writing an enable bit to 0 removes that source from the pending set. Its flag bit is left unchanged.
- R4: Writing 1 to a flag bit clears the flag and removes the source from the pending set. Writing 0 to a flag bit leaves it unchanged. A set strobe in the same cycle as a clearing write wins, so the flag ends at 1.
- R5: When several sources are pending, the lowest-numbered one is offered. Its vector is `VEC_BASE + i*VEC_STEP`, which is 2+2i by default.
- R6: `dispValid` is high only while `globalEn` is 1. Pending sources are retained while `globalEn` is 0.
- R7: When the core accepts a pulse-type source (`dispValid && dispReady` at a clock edge), that source's flag is cleared and the source leaves the pending set.
- R8: A set strobe on a level-type source drives its flag to 0, and the source becomes pending if enabled. The source stays pending after the core accepts it.
- R9: After each acceptance, `dispValid` stays low for the next `TAKE_CYCLES` (2) cycles. At most one vector is accepted per cycle.
- R10: Register byte k (`wrIdx`=k) holds sources 8k..8k+7, with source i at data bit i-8k. `wrEnableReg`=1 selects the enable bank and 0 selects the flag bank. Data bits above `NUM_SRC`-1 are ignored.
- R11: Reset clears all flags, all enables, the pending set and the wait counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| setStb | input | NUM_SRC | One-cycle flag-set events, one per source |
| wrEn | input | 1 | Register byte write strobe |
| wrEnableReg | input | 1 | 1 writes the enable bank, 0 writes ones-to-clear into the flag bank |
| wrIdx | input | REG_IDX_W | Byte index within the selected bank |
| wrData | input | 8 | Write data |
| globalEn | input | 1 | Global interrupt enable from the core status register |
| dispValid | output | 1 | A vector is offered to the core |
| dispReady | input | 1 | Core accepts the offered vector |
| dispVector | output | VEC_W | Vector address of the offered source |
| flagBits | output | NUM_SRC | Current flag register contents |
| enableBits | output | NUM_SRC | Current enable register contents |

## Verification
The stimulus arrives in several distinct patterns:

- A flag raised before and after its enable, which separates the set path from the enable-write path.
- Two sources pending together, where the offered vector shows whether priority follows the index.
- A pending source held across a window with `globalEn` low, which shows that gating drops nothing.
- One level-type source accepted repeatedly, which checks both that the source persists and that the two-cycle gap is applied each time.
- A set coinciding with a clearing write, and writes into the upper byte with out-of-range bits, which check the update order and the register layout.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  // Width of the source index carried from control to datapath (up to 256 sources).
  localparam int unsigned IDX_W = 8;

  // Strobes from the dispatch control to the pending datapath.
  typedef struct packed {
    logic             take;     // vector accepted this cycle
    logic [IDX_W-1:0] takeIdx;  // source number that was accepted
  } takeCtl_t;
endpackage

// File: rtl/irq_pend_datapath.sv
module irq_pend_datapath
  import irq_pend_pkg::*;
#(
  parameter int unsigned NUM_SRC = 12,
  parameter int unsigned REG_IDX_W = 1,
  parameter logic [NUM_SRC-1:0] LEVEL_SRC = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   setStb,
  input  logic                 wrEn,
  input  logic                 wrEnableReg,
  input  logic [REG_IDX_W-1:0] wrIdx,
  input  logic [7:0]           wrData,
  input  takeCtl_t             ctl,
  output logic [NUM_SRC-1:0]   flagBits,
  output logic [NUM_SRC-1:0]   enableBits,
  output logic [NUM_SRC-1:0]   pendBits
);
  logic [NUM_SRC-1:0] flagQ, enQ, pendQ;
  logic [NUM_SRC-1:0] flagN, enN, pendN;
  logic [NUM_SRC-1:0] byteSel, wrBit;
  logic [NUM_SRC-1:0] takeMask, pulseTake, flagWr, enWr;

  // Spread the written byte over the source bits it addresses (R10).
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
    assign byteSel[g] = (wrIdx == REG_IDX_W'(g / 8));
    assign wrBit[g]   = wrData[g % 8];
    assign takeMask[g] = ctl.take && (ctl.takeIdx == IDX_W'(g));
  end

  assign pulseTake = takeMask & ~LEVEL_SRC;
  assign flagWr = {NUM_SRC{wrEn && !wrEnableReg}} & byteSel & wrBit;
  assign enWr   = {NUM_SRC{wrEn && wrEnableReg}} & byteSel;

  // Update order: dispatch retire, clearing write, enable write, set event.
  always_comb begin
    flagN = flagQ & ~pulseTake;
    pendN = pendQ & ~pulseTake;
    flagN = flagN & ~flagWr;
    pendN = pendN & ~flagWr;
    enN   = (enQ & ~enWr) | (enWr & wrBit);
    pendN = (pendN & ~(enWr & ~wrBit)) | (enWr & wrBit & flagN);
    flagN = (flagN | (setStb & ~LEVEL_SRC)) & ~(setStb & LEVEL_SRC);
    pendN = pendN | (setStb & enN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
      pendQ <= '0;
    end else begin
      flagQ <= flagN;
      enQ   <= enN;
      pendQ <= pendN;
    end
  end

  assign flagBits   = flagQ;
  assign enableBits = enQ;
  assign pendBits   = pendQ;

  // R3: a pending source always has its enable bit set
  a_r3_pend_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ & ~enQ) == '0);

  // R4: ones written to the flag bank clear flag and pending when no set collides
  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrEnableReg && setStb == '0) |=>
      ((flagQ & $past(flagWr)) == '0) && ((pendQ & $past(flagWr)) == '0));

  // R3: a zero written to an enable bit drops pending and keeps the flag
  a_r3_mask_off: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrEnableReg && setStb == '0 && !ctl.take) |=>
      ((pendQ & $past(enWr & ~wrBit)) == '0) && (flagQ == $past(flagQ)));

  // R7: an accepted pulse source loses its flag
  a_r7_pulse_retired: assert property (@(posedge clk) disable iff (!rstN)
    (|pulseTake && setStb == '0) |=> ((flagQ & $past(pulseTake)) == '0));

  // R8: an accepted level source stays pending when no write touches it
  a_r8_level_kept: assert property (@(posedge clk) disable iff (!rstN)
    (|(takeMask & LEVEL_SRC) && !wrEn) |=> |(pendQ & $past(takeMask)));
endmodule

// File: rtl/irq_pend_dispatch.sv
module irq_pend_dispatch
  import irq_pend_pkg::*;
#(
  parameter int unsigned NUM_SRC = 12,
  parameter int unsigned VEC_W = 8,
  parameter int unsigned VEC_BASE = 2,
  parameter int unsigned VEC_STEP = 2,
  parameter int unsigned TAKE_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendBits,
  input  logic               globalEn,
  input  logic               dispReady,
  output logic               dispValid,
  output logic [VEC_W-1:0]   dispVector,
  output takeCtl_t           ctl
);
  localparam int unsigned HOLD_W = (TAKE_CYCLES > 0) ? $clog2(TAKE_CYCLES + 1) : 1;

  logic [IDX_W-1:0]  selIdx;
  logic              anyPend;
  logic [HOLD_W-1:0] holdCnt;

  // Lowest-numbered pending source wins (R5).
  always_comb begin
    anyPend = 1'b0;
    selIdx  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendBits[i]) begin
        anyPend = 1'b1;
        selIdx  = IDX_W'(i);
      end
    end
  end

  assign dispValid   = globalEn && anyPend && (holdCnt == '0);
  assign dispVector  = VEC_W'(VEC_BASE + 32'(selIdx) * VEC_STEP);
  assign ctl.take    = dispValid && dispReady;
  assign ctl.takeIdx = selIdx;

  // Wait out the core's interrupt entry after each acceptance (R9).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (ctl.take) begin
      holdCnt <= HOLD_W'(TAKE_CYCLES);
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  // R5: the offered vector belongs to a source the datapath holds pending
  a_r5_offer_is_pending: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> pendBits[selIdx[$clog2(NUM_SRC)-1:0]]);

  // R6: nothing is offered while the global enable is low
  a_r6_gated: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !dispValid);

  if (TAKE_CYCLES >= 1) begin : g_gap1
    // R9: no offer in the cycle after an acceptance
    a_r9_gap_first: assert property (@(posedge clk) disable iff (!rstN)
      ctl.take |=> !dispValid);
  end
  if (TAKE_CYCLES >= 2) begin : g_gap2
    // R9: no offer two cycles after an acceptance
    a_r9_gap_second: assert property (@(posedge clk) disable iff (!rstN)
      $past(ctl.take, 2) |-> !dispValid);
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int unsigned NUM_SRC = 12,
  parameter int unsigned VEC_W = 8,
  parameter int unsigned VEC_BASE = 2,
  parameter int unsigned VEC_STEP = 2,
  parameter int unsigned TAKE_CYCLES = 2,
  parameter logic [NUM_SRC-1:0] LEVEL_SRC = 12'h020,
  localparam int unsigned NUM_REGS = (NUM_SRC + 7) / 8,
  localparam int unsigned REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   setStb,
  input  logic                 wrEn,
  input  logic                 wrEnableReg,
  input  logic [REG_IDX_W-1:0] wrIdx,
  input  logic [7:0]           wrData,
  input  logic                 globalEn,
  output logic                 dispValid,
  input  logic                 dispReady,
  output logic [VEC_W-1:0]     dispVector,
  output logic [NUM_SRC-1:0]   flagBits,
  output logic [NUM_SRC-1:0]   enableBits
);
  takeCtl_t           ctl;
  logic [NUM_SRC-1:0] pendBits;

  initial begin
    if (NUM_SRC < 2 || NUM_SRC > 256) $error("NUM_SRC out of range");
  end

  irq_pend_datapath #(
    .NUM_SRC(NUM_SRC), .REG_IDX_W(REG_IDX_W), .LEVEL_SRC(LEVEL_SRC)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .setStb(setStb), .wrEn(wrEn),
    .wrEnableReg(wrEnableReg), .wrIdx(wrIdx), .wrData(wrData), .ctl(ctl),
    .flagBits(flagBits), .enableBits(enableBits), .pendBits(pendBits)
  );

  irq_pend_dispatch #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP), .TAKE_CYCLES(TAKE_CYCLES)
  ) i_dispatch (
    .clk(clk), .rstN(rstN), .pendBits(pendBits), .globalEn(globalEn),
    .dispReady(dispReady), .dispValid(dispValid), .dispVector(dispVector),
    .ctl(ctl)
  );
endmodule

// File: tb/test_irq_pend_ctrl.sv
module test_irq_pend_ctrl;
  localparam int NS = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] setStb = '0;
  logic          wrEn = 1'b0, wrEnableReg = 1'b0;
  logic [0:0]    wrIdx = '0;
  logic [7:0]    wrData = '0;
  logic          globalEn = 1'b1, dispReady = 1'b0;
  logic          dispValid;
  logic [7:0]    dispVector;
  logic [NS-1:0] flagBits, enableBits;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_pend_ctrl #(
    .NUM_SRC(NS), .VEC_W(8), .VEC_BASE(2), .VEC_STEP(2),
    .TAKE_CYCLES(2), .LEVEL_SRC(12'h020)
  ) i_irq_pend_ctrl (
    .clk(clk), .rstN(rstN), .setStb(setStb), .wrEn(wrEn),
    .wrEnableReg(wrEnableReg), .wrIdx(wrIdx), .wrData(wrData),
    .globalEn(globalEn), .dispValid(dispValid), .dispReady(dispReady),
    .dispVector(dispVector), .flagBits(flagBits), .enableBits(enableBits)
  );

  typedef struct packed {
    logic [3:0]    rq;
    logic          gie, rdy;
    logic [NS-1:0] set;
    logic          wr, sel;
    logic          idx;
    logic [7:0]    data;
    logic          expValid;
    logic [7:0]    expVec;
    logic [NS-1:0] expFlag, expEn;
  } step_t;

  localparam int NSTEP = 28;
  // Each row: one cycle of inputs, then the outputs expected after that edge.
  localparam step_t STEPS [NSTEP] = '{
    '{4'd1,  1,0,12'h002,0,0,0,8'h00, 0,8'h00,12'h002,12'h000}, // R1 set while disabled
    '{4'd2,  1,0,12'h000,1,1,0,8'h03, 1,8'h04,12'h002,12'h003}, // R2 enable with flag up
    '{4'd5,  1,0,12'h001,0,0,0,8'h00, 1,8'h02,12'h003,12'h003}, // R5 lower index wins
    '{4'd7,  1,1,12'h000,0,0,0,8'h00, 0,8'h00,12'h002,12'h003}, // R7 pulse accepted
    '{4'd9,  1,1,12'h000,0,0,0,8'h00, 0,8'h00,12'h002,12'h003}, // R9 gap cycle 1
    '{4'd9,  1,1,12'h000,0,0,0,8'h00, 1,8'h04,12'h002,12'h003}, // R9 gap over
    '{4'd6,  0,1,12'h000,0,0,0,8'h00, 0,8'h00,12'h002,12'h003}, // R6 gated, no take
    '{4'd6,  1,0,12'h000,0,0,0,8'h00, 1,8'h04,12'h002,12'h003}, // R6 pending retained
    '{4'd4,  1,0,12'h000,1,0,0,8'h02, 0,8'h00,12'h000,12'h003}, // R4 write-1 clear
    '{4'd1,  1,0,12'h001,0,0,0,8'h00, 1,8'h02,12'h001,12'h003}, // R1 set while enabled
    '{4'd4,  1,0,12'h000,1,0,0,8'h00, 1,8'h02,12'h001,12'h003}, // R4 zero write no effect
    '{4'd3,  1,0,12'h000,1,1,0,8'h00, 0,8'h00,12'h001,12'h000}, // R3 mask off keeps flag
    '{4'd2,  1,0,12'h000,1,1,0,8'h01, 1,8'h02,12'h001,12'h001}, // R2 re-enable
    '{4'd10, 1,0,12'h000,1,1,0,8'h21, 1,8'h02,12'h001,12'h021}, // R10 enable byte 0
    '{4'd8,  1,0,12'h020,0,0,0,8'h00, 1,8'h02,12'h001,12'h021}, // R8 level set, flag 0
    '{4'd4,  1,0,12'h000,1,0,0,8'h01, 1,8'h0C,12'h000,12'h021}, // R4 clear src0
    '{4'd8,  1,1,12'h000,0,0,0,8'h00, 0,8'h00,12'h000,12'h021}, // R8 level accepted
    '{4'd9,  1,1,12'h000,0,0,0,8'h00, 0,8'h00,12'h000,12'h021}, // R9 gap
    '{4'd9,  1,1,12'h000,0,0,0,8'h00, 1,8'h0C,12'h000,12'h021}, // R9 gap over
    '{4'd8,  1,1,12'h000,0,0,0,8'h00, 0,8'h00,12'h000,12'h021}, // R8 accepted again
    '{4'd9,  1,0,12'h000,0,0,0,8'h00, 0,8'h00,12'h000,12'h021}, // R9 gap
    '{4'd9,  1,0,12'h000,0,0,0,8'h00, 1,8'h0C,12'h000,12'h021}, // R9 still pending
    '{4'd10, 1,0,12'h000,1,1,1,8'hFF, 1,8'h0C,12'h000,12'hF21}, // R10 upper byte, extra bits dropped
    '{4'd5,  1,0,12'h800,0,0,0,8'h00, 1,8'h0C,12'h800,12'hF21}, // R5 src5 before src11
    '{4'd3,  1,0,12'h000,1,1,0,8'h00, 1,8'h18,12'h800,12'hF00}, // R3 drop src5
    '{4'd7,  1,1,12'h000,0,0,0,8'h00, 0,8'h00,12'h000,12'hF00}, // R7 src11 retired
    '{4'd4,  1,0,12'h100,1,0,1,8'h01, 0,8'h00,12'h100,12'hF00}, // R4 set beats clear
    '{4'd9,  1,0,12'h000,0,0,0,8'h00, 1,8'h12,12'h100,12'hF00}  // R9 offer after gap
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    setStb = '0; wrEn = 1'b0; wrEnableReg = 1'b0; wrIdx = '0; wrData = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R11: state after reset
    chk("R11 reset valid", 32'(dispValid), 0);
    chk("R11 reset flags", 32'(flagBits), 0);
    chk("R11 reset enables", 32'(enableBits), 0);
    rstN = 1'b1;

    for (int s = 0; s < NSTEP; s++) begin
      globalEn = STEPS[s].gie;
      dispReady = STEPS[s].rdy;
      setStb = STEPS[s].set;
      wrEn = STEPS[s].wr;
      wrEnableReg = STEPS[s].sel;
      wrIdx = STEPS[s].idx;
      wrData = STEPS[s].data;
      @(negedge clk);
      chk($sformatf("R%0d step %0d valid", STEPS[s].rq, s), 32'(dispValid), 32'(STEPS[s].expValid));
      if (STEPS[s].expValid)
        chk($sformatf("R%0d step %0d vector", STEPS[s].rq, s), 32'(dispVector), 32'(STEPS[s].expVec));
      chk($sformatf("R%0d step %0d flags", STEPS[s].rq, s), 32'(flagBits), 32'(STEPS[s].expFlag));
      chk($sformatf("R%0d step %0d enables", STEPS[s].rq, s), 32'(enableBits), 32'(STEPS[s].expEn));
      idle();
      dispReady = 1'b0;
    end

    // R11: reset in the middle of activity
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R11 mid reset valid", 32'(dispValid), 0);
    chk("R11 mid reset flags", 32'(flagBits), 0);
    chk("R11 mid reset enables", 32'(enableBits), 0);
    // R11 / R2: enables are gone, so a new set raises only the flag
    setStb = 12'h100;
    @(negedge clk);
    idle();
    chk("R11 set after reset flags", 32'(flagBits), 32'h100);
    chk("R11 set after reset valid", 32'(dispValid), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule